// File: doc/BRIEF.md
# Two-Bit Burst Address Sequencer

This block produces the address for each beat of a four-beat burst. On a load cycle it takes a complete start address from the bus and presents it unchanged. On each following advance cycle it steps a two-bit beat counter, and it recomputes only the two lowest address bits from the stored start and that counter. The upper bits stay as they were captured at the load.

Two orderings are available. In linear order the low bits count upward from the start and wrap inside the aligned group of four. In interleaved order the low bits are the start XOR-ed with the beat count. The order is sampled together with the address on the load cycle. A clock enable freezes the whole sequencer. While it is low, every other input is ignored.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rst_n` is low, `addr_out` is all zeros and `beat` is 0.
- R2: A cycle with `clk_en`=1 and `load`=1 makes `addr_out` equal to that cycle's `addr_in` and `beat` equal to 0 after the clock edge.
- R3: A cycle with `clk_en`=1 and `load`=0 raises `beat` by one, modulo 4, after the clock edge.
- R4: In linear order (`interleave`=0 at the last load), `addr_out[1:0]` equals (start low bits + `beat`) mod 4.
- R5: In interleaved order (`interleave`=1 at the last load), `addr_out[1:0]` equals start low bits XOR `beat`.
- R6: `interleave` is sampled only on a load cycle. Changing it during advance cycles does not alter the ordering.
- R7: During advance cycles `addr_out[AW-1:2]` keeps the value captured at the last load.
- R8: While `clk_en` is 0, `addr_out` and `beat` hold their values, and `load`, `interleave` and `addr_in` have no effect.
- R9: After four advance cycles in either order, `addr_out` returns to the start address loaded for that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_en | input | 1 | 1 lets the sequencer act on this edge, 0 freezes it |
| load | input | 1 | 1 loads a new start address, 0 advances the burst |
| interleave | input | 1 | Ordering taken at load: 0 linear, 1 interleaved |
| addr_in | input | AW | Start address taken at load |
| addr_out | output | AW | Current beat address |
| beat | output | 2 | Beat index since the last load |

## Verification
The assertions assume that reset is asserted before the first clock edge and that `clk_en` and `load` carry known values on every sampled edge. If either were X, the antecedents of the load, advance and hold properties would become undefined. The stimulus sets every input before reset is released. It changes inputs only on the falling clock edge, so each rising edge samples one settled vector. The stimulus also covers long frozen stretches with `load` high and a changing `addr_in`, and it toggles `interleave` in the middle of bursts.

// File: rtl/burst_addr_gen.sv
module burst_addr_gen #(
  parameter int AW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clk_en,
  input  logic          load,
  input  logic          interleave,
  input  logic [AW-1:0] addr_in,
  output logic [AW-1:0] addr_out,
  output logic [1:0]    beat
);
  localparam int UW = AW - 2;

  logic [UW-1:0] upper_q;
  logic [1:0]    start_q;
  logic [1:0]    cnt_q;
  logic          ilv_q;
  logic [1:0]    low;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upper_q <= '0;
      start_q <= '0;
      cnt_q   <= '0;
      ilv_q   <= 1'b0;
    end else if (clk_en) begin
      if (load) begin
        upper_q <= addr_in[AW-1:2];
        start_q <= addr_in[1:0];
        cnt_q   <= '0;
        ilv_q   <= interleave;
      end else begin
        cnt_q   <= cnt_q + 2'd1;
      end
    end
  end

  assign low      = ilv_q ? (start_q ^ cnt_q) : (start_q + cnt_q);
  assign addr_out = {upper_q, low};
  assign beat     = cnt_q;
endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
  parameter int AW = 20
) (
  input logic          clk,
  input logic          rst_n,
  input logic          clk_en,
  input logic          load,
  input logic          interleave,
  input logic [AW-1:0] addr_in,
  input logic [AW-1:0] addr_out,
  input logic [1:0]    beat
);
  AST_RESET_ZERO: assert property (@(posedge clk) !rst_n |-> (addr_out == '0 && beat == 2'd0)); // R1
  AST_LOAD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en && load |=> addr_out == $past(addr_in)); // R2
  AST_LOAD_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en && load |=> beat == 2'd0); // R2
  AST_BEAT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en && !load |=> beat == 2'($past(beat) + 2'd1)); // R3
  AST_UPPER_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en && !load |=> $stable(addr_out[AW-1:2])); // R7
  AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |=> $stable(addr_out) && $stable(beat)); // R8
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.AW(AW)) u_chk (.*);

// File: tb/burst_addr_gen_bench.sv
`timescale 1ns/1ps
module burst_addr_gen_bench;
  localparam int AW = 20;

  typedef struct {
    logic [AW-1:0] addr;
    logic [1:0]    beat;
    string         tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          clk_en = 1'b0;
  logic          load = 1'b0;
  logic          interleave = 1'b0;
  logic [AW-1:0] addr_in = '0;
  logic [AW-1:0] addr_out;
  logic [1:0]    beat;

  int   n_vec = 0;
  int   n_bad = 0;
  exp_t sb[$];

  logic [AW-3:0] m_up = '0;
  logic [1:0]    m_st = '0;
  logic [1:0]    m_cnt = '0;
  logic          m_ilv = 1'b0;

  always #2 clk = ~clk;

  burst_addr_gen #(.AW(AW)) u_burst_addr_gen (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .load(load),
    .interleave(interleave), .addr_in(addr_in),
    .addr_out(addr_out), .beat(beat)
  );

  task automatic step(input logic en, input logic ld, input logic ilv,
                      input logic [AW-1:0] a, input string tag);
    exp_t e;
    logic [1:0] lo;
    @(negedge clk);
    clk_en = en; load = ld; interleave = ilv; addr_in = a;
    if (en) begin
      if (ld) begin
        m_up = a[AW-1:2]; m_st = a[1:0]; m_cnt = 2'd0; m_ilv = ilv;
      end else begin
        m_cnt = m_cnt + 2'd1;
      end
    end
    lo = m_ilv ? (m_st ^ m_cnt) : 2'(m_st + m_cnt);
    e.addr = {m_up, lo};
    e.beat = m_cnt;
    e.tag  = tag;
    sb.push_back(e);
  endtask

  always @(posedge clk) begin
    #1;
    if (rst_n && sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      n_vec++;
      if (addr_out !== e.addr || beat !== e.beat) begin
        n_bad++;
        $display("FAIL %s: addr=%h beat=%0d expected addr=%h beat=%0d",
                 e.tag, addr_out, beat, e.addr, e.beat);
      end
    end
  end

  initial begin
    #4000000;
    n_bad++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [AW-1:0] base;
    repeat (3) @(negedge clk);
    n_vec++;
    if (addr_out !== '0 || beat !== 2'd0) begin
      n_bad++;
      $display("FAIL R1: addr=%h beat=%0d expected addr=0 beat=0", addr_out, beat);
    end
    rst_n = 1'b1;

    step(1, 1, 0, 20'h12345, "R2 linear load");
    for (int i = 0; i < 4; i++) step(1, 0, 0, 20'hFFFFF, "R4 R7 linear advance");
    step(1, 0, 0, 20'h0, "R9 linear wrap plus one");

    step(1, 1, 1, 20'hABCDE, "R2 interleaved load");
    for (int i = 0; i < 4; i++) step(1, 0, 1, 20'h00000, "R5 R9 interleaved advance");

    step(1, 1, 0, 20'h55557, "R2 load for freeze");
    step(1, 0, 0, 20'h0, "R3 advance");
    for (int i = 0; i < 5; i++) step(0, 1, 1, 20'(i * 20'h1111), "R8 frozen");
    step(0, 0, 0, 20'h0, "R8 frozen advance");
    step(1, 0, 0, 20'h0, "R3 resume");

    step(1, 1, 1, 20'h0F0F1, "R2 load interleaved");
    step(1, 0, 0, 20'h0, "R6 mode flipped mid burst");
    step(1, 0, 1, 20'h0, "R6 mode back");
    step(1, 0, 0, 20'h0, "R6 mode flipped again");

    for (int m = 0; m < 2; m++) begin
      for (int s = 0; s < 4; s++) begin
        base = 20'(20'h3C000 + (s * 20'h00404) + s);
        step(1, 1, logic'(m), base, m ? "R5 sweep load" : "R4 sweep load");
        for (int k = 0; k < 4; k++)
          step(1, 0, logic'(~m), 20'hFFFFF, m ? "R5 R9 sweep" : "R4 R9 sweep");
      end
    end

    step(1, 1, 0, 20'h00002, "R2 back to back load");
    step(1, 1, 1, 20'h00003, "R2 back to back load");
    step(1, 0, 0, 20'h0, "R5 after reload");

    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule